// File: doc/BRIEF.md
# Lockable Flash Timing Clock Divider

This block holds the 8-bit control register that sets the timing base for flash program and erase sequencing, and it contains the prescaler that turns the bus clock into a timing tick of about 1 MHz. Software writes a 6-bit divide value, chosen so that the bus clock divided by (value + 1) comes close to 1 MHz. The prescaler then raises `tick` once per (value + 1) bus cycles. The program and erase sequencers count these ticks to time their events.

The register also carries two protection bits. A sticky status flag shows that the register has been written since reset. A lock bit can only be set, and once set it freezes the divide value until the next reset. An active debug mode lifts the lock rules, so that bits 6..0 can be rewritten freely. Whenever a flash command is in progress (`cmd_done` low), every write is dropped.

Register layout: bit 7 = loaded flag, bit 6 = lock, bits 5..0 = divide value.

Top module: `flash_tick_div`

## Requirements
- R1: A synchronous reset clears the register, so `rd_data` reads 0x00 on the cycle after reset.
- R2: Bit 7, the loaded flag, reads 0 until the first accepted write. It reads 1 from the cycle after any accepted write until the next reset, and the value written to bit 7 is ignored.
- R3: In user mode (`dbg_mode`=0), writing 1 to bit 6 sets the lock. Writing 0 to bit 6 leaves a set lock at 1.
- R4: While the lock is 1 in user mode, an accepted write leaves bits 5..0 unchanged. It still sets the loaded flag. A write that sets the lock also writes bits 5..0 in the same cycle, because the lock was still clear when that write arrived.
- R5: In debug mode (`dbg_mode`=1), an accepted write copies `wr_data[6:0]` into bits 6..0, whatever the lock state. This includes clearing the lock.
- R6: A write presented while `cmd_done`=0 changes no register bit, including the loaded flag.
- R7: With divide value D, `tick` is high for one cycle in every D+1 cycles. For D>=1 each pulse is exactly one cycle wide. For D=0, `tick` is high on every cycle.
- R8: An accepted write that changes the divide value restarts the prescaler, so the first tick arrives D+1 cycles after the accepting clock edge. A write that leaves the divide value unchanged does not shift the tick phase.
- R9: `rd_data` always shows all eight register bits, in both user mode and debug mode. It updates on the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data (bit 7 ignored) |
| dbg_mode | input | 1 | 1 = debug mode, lock rules lifted |
| cmd_done | input | 1 | Command-complete flag; 0 = command running, writes dropped |
| rd_data | output | 8 | Register contents {loaded, lock, divide} |
| tick | output | 1 | Registered timing pulse, once per divide+1 cycles |

## Verification
The assertions assume that `dbg_mode` and `cmd_done` are stable around each clock edge and that the mode seen at the edge that takes a write is the mode that applies to that write. The bench meets this by changing every input only on the falling edge. The pulse-width property assumes that a divide value of zero is the only case in which ticks may touch. The phase checks assume that no second write lands inside a measured interval, so the bench issues at most one single-cycle write between two tick measurements.

// File: rtl/flash_tick_pkg.sv
package flash_tick_pkg;
  parameter int unsigned TDIV_DIV_W = 6;

  typedef enum logic {
    ACCESS_USER  = 1'b0,
    ACCESS_DEBUG = 1'b1
  } access_mode_e;
endpackage

// File: rtl/tdiv_regs.sv
module tdiv_regs #(
  parameter int unsigned DIV_W = flash_tick_pkg::TDIV_DIV_W,
  localparam int unsigned REG_W = DIV_W + 2,
  localparam int unsigned LOCK_BIT = DIV_W,
  localparam int unsigned LOAD_BIT = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             dbg_mode,
  input  logic             cmd_done,
  output logic [REG_W-1:0] reg_q,
  output logic [DIV_W-1:0] div_q,
  output logic             reload
);
  import flash_tick_pkg::*;

  logic             loaded_q;
  logic             lock_q;
  logic             accept;
  logic             div_open;
  logic             nxt_lock;
  logic [DIV_W-1:0] nxt_div;
  access_mode_e     mode;

  always_comb begin
    mode     = dbg_mode ? ACCESS_DEBUG : ACCESS_USER;
    accept   = wr_en & cmd_done;
    div_open = (mode == ACCESS_DEBUG) | ~lock_q;
    if (mode == ACCESS_DEBUG) begin
      nxt_lock = wr_data[LOCK_BIT];
    end else begin
      nxt_lock = lock_q | wr_data[LOCK_BIT];
    end
    nxt_div = div_open ? wr_data[DIV_W-1:0] : div_q;
    reload  = accept && (nxt_div != div_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q <= 1'b0;
      lock_q   <= 1'b0;
      div_q    <= '0;
    end else if (accept) begin
      loaded_q <= 1'b1;
      lock_q   <= nxt_lock;
      div_q    <= nxt_div;
    end
  end

  assign reg_q = {loaded_q, lock_q, div_q};
endmodule

// File: rtl/tdiv_prescaler.sv
module tdiv_prescaler #(
  parameter int unsigned DIV_W = flash_tick_pkg::TDIV_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_q,
  input  logic             reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_tick_div.sv
module flash_tick_div #(
  parameter int unsigned DIV_W = flash_tick_pkg::TDIV_DIV_W,
  localparam int unsigned REG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             dbg_mode,
  input  logic             cmd_done,
  output logic [REG_W-1:0] rd_data,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic             reload;

  tdiv_regs #(.DIV_W(DIV_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .dbg_mode (dbg_mode),
    .cmd_done (cmd_done),
    .reg_q    (rd_data),
    .div_q    (div_q),
    .reload   (reload)
  );

  tdiv_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .div_q  (div_q),
    .reload (reload),
    .tick   (tick)
  );
endmodule

// File: rtl/flash_tick_div_chk.sv
module flash_tick_div_chk #(
  parameter int unsigned DIV_W = 6,
  localparam int unsigned REG_W = DIV_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             dbg_mode,
  input logic             cmd_done,
  input logic [REG_W-1:0] rd_data,
  input logic             tick
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

  // R2
  loaded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1] |=> rd_data[REG_W-1]);

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[DIV_W] && !dbg_mode) |=> rd_data[DIV_W]);

  // R4
  locked_div_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[DIV_W] && !dbg_mode) |=> $stable(rd_data[DIV_W-1:0]));

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_done |=> $stable(rd_data));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (rd_data[DIV_W-1:0] != '0)) |=> !tick);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cmd_done && (dbg_mode || !rd_data[DIV_W]) &&
     (wr_data[DIV_W-1:0] != rd_data[DIV_W-1:0])) |=> !tick);
endmodule

bind flash_tick_div flash_tick_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .dbg_mode (dbg_mode),
  .cmd_done (cmd_done),
  .rd_data  (rd_data),
  .tick     (tick)
);

// File: tb/sim_flash_tick_div.sv
`timescale 1ns/1ps
module sim_flash_tick_div;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       dbg_mode = 1'b0;
  logic       cmd_done = 1'b1;
  logic [7:0] rd_data;
  logic       tick;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  flash_tick_div u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .dbg_mode(dbg_mode), .cmd_done(cmd_done), .rd_data(rd_data), .tick(tick)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic dbg, input logic done);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; dbg_mode = dbg; cmd_done = done;
    @(negedge clk);
    wr_en = 1'b0; cmd_done = 1'b1;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n = n + 1;
      if (tick) break;
    end
  endtask

  initial begin
    int n;
    int exp_reg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset value", rd_data, 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 divide 0 ticks every cycle", tick, 1);
    end

    wr(8'hFF, 1'b0, 1'b0);
    chk("R6 busy user write dropped", rd_data, 8'h00);
    chk("R2 loaded clear before write", rd_data[7], 0);

    wr(8'h05, 1'b0, 1'b1);
    chk("R2 loaded set by write", rd_data, 8'h85);
    wr(8'h03, 1'b0, 1'b1);
    chk("R9 user read of register", rd_data, 8'h83);
    wait_tick(n);
    chk("R8 first tick after change", n, 4);
    wait_tick(n);
    chk("R7 period divide 3", n, 4);

    wr(8'h4A, 1'b0, 1'b1);
    chk("R3 lock set with divide", rd_data, 8'hCA);
    wait_tick(n);
    chk("R8 restart divide 10", n, 11);
    wr(8'h01, 1'b0, 1'b1);
    chk("R4 locked divide unchanged", rd_data, 8'hCA);
    chk("R3 lock not cleared in user mode", rd_data[6], 1);
    wait_tick(n);
    chk("R4 locked write keeps phase", n + 2, 11);

    wr(8'h00, 1'b1, 1'b0);
    chk("R6 busy debug write dropped", rd_data, 8'hCA);
    wr(8'h07, 1'b1, 1'b1);
    chk("R5 debug clears lock", rd_data, 8'h87);

    for (int d = 63; d >= 0; d--) begin
      exp_reg = 8'h80 | ((d & 1) << 6) | d;
      wr(8'(exp_reg & 8'h7F), 1'b1, 1'b1);
      chk("R5 debug write sweep", rd_data, exp_reg);
      chk("R9 debug read sweep", rd_data, exp_reg);
      wait_tick(n);
      chk("R8 first tick sweep", n, d + 1);
      wait_tick(n);
      chk("R7 period sweep", n, d + 1);
      @(negedge clk);
      chk("R7 pulse width sweep", tick, (d == 0) ? 1 : 0);
    end

    wr(8'h09, 1'b0, 1'b1);
    wait_tick(n);
    chk("R8 restart divide 9", n, 10);
    wr(8'h09, 1'b0, 1'b1);
    chk("R2 loaded stays set", rd_data, 8'h89);
    wait_tick(n);
    chk("R8 unchanged divide keeps phase", n + 2, 10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule